// File: doc/BRIEF.md
# Two-Channel Debug Break Controller

This block observes a processor's access stream (instruction fetches, data reads and data writes) and raises a user break request when a programmed condition matches. It has two comparison channels, A and B. Each channel holds a compare address, a don't-care mask, an access kind and a timing select. The timing select chooses whether a fetch match breaks before or after the instruction executes. Each channel has a sticky match flag. A sequential mode makes a break depend on a channel A match followed later by a channel B match.

A break request carries the PC that the handler will save and the handler entry address. Two matches that would save the same PC in back-to-back cycles give a single request. A post-execution break loses to a completed-type or re-execution-type exception that arrives in the same cycle, but its flag is still set. The block also keeps a copy of the stack pointer taken at every exception event. It also tracks the exception block bit, including the delay slot of a return.

The pipeline, the exception unit and the register decoding are modelled as plain strobes and value ports.

Top module: `dbgBreakCtl`

## Requirements
- R1: A channel matches in a cycle when `accValid` is 1, `accType` equals the channel's kind (0 = fetch, 1 = data read, 2 = data write) and `(accAddr & ~mask) == (chanAddr & ~mask)`. The channel's flag reads 1 from the next cycle on.
- R2: A flag stays 1 until a cycle with `flagWrEn` = 1 and a 0 in its bit of `flagWrData` (bit 0 = A, bit 1 = B). Writing 1 leaves a flag unchanged. A clear and a match in the same cycle leave the flag at 1.
- R3: The break PC of a fetch match is `accPc` when the timing select is 0 (pre-execution) and `accPc + 2` when it is 1 (post-execution). A data match always uses `accPc + 2`, whatever its timing select holds.
- R4: A break candidate in cycle t gives a one-cycle `brkReq` in cycle t+1, with `brkPc` and `brkTarget` valid in that cycle. No other cycle carries `brkReq`.
- R5: A candidate whose break PC equals the `brkPc` of the request shown in the same cycle gives no new request, but its flag is set. If both channels give candidates in one cycle, one request is raised, and a pre-execution candidate is preferred over a post-execution one (A on a tie).
- R6: With `seqMode` = 1, a channel A match never breaks. A channel B match breaks only when a channel A match came in an earlier cycle since the last such B match. Every B match returns the sequence to idle. Both flags are set as usual.
- R7: A post-execution candidate in a cycle with `excCompleted` or `excReexec` = 1 raises no request, but its flag is set. A pre-execution candidate is not affected.
- R8: `brkTarget` is `dbgBase` when `debugEn` = 1 and `vecBase + 0x100` otherwise. It is sampled in the candidate cycle.
- R9: `savedSp` takes `spIn` at every cycle that has `brkReq` = 1 or `excAccept` = 1, whatever `debugEn` holds.
- R10: `blockBit` resets to 1 and reads 1 from the cycle after any `brkReq` or `excAccept`. After `retStart` in cycle t it keeps its old value in cycle t+1 (the delay slot) and shows the `retBl` sampled at t from cycle t+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe |
| accType | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| accAddr | input | AW | Access address |
| accPc | input | AW | PC of the instruction making the access |
| aAddr | input | AW | Channel A compare address |
| aMask | input | AW | Channel A don't-care mask |
| aType | input | 2 | Channel A access kind |
| aPost | input | 1 | Channel A post-execution select |
| bAddr | input | AW | Channel B compare address |
| bMask | input | AW | Channel B don't-care mask |
| bType | input | 2 | Channel B access kind |
| bPost | input | 1 | Channel B post-execution select |
| seqMode | input | 1 | Sequential A-then-B mode |
| debugEn | input | 1 | Branch to debug base |
| dbgBase | input | AW | Debug handler address |
| vecBase | input | AW | Vector base |
| flagWrEn | input | 1 | Flag write strobe |
| flagWrData | input | 2 | Flag write data; 0 clears |
| excCompleted | input | 1 | Completed-type exception this cycle |
| excReexec | input | 1 | Re-execution-type exception this cycle |
| excAccept | input | 1 | Another exception accepted this cycle |
| spIn | input | AW | Current stack pointer |
| retStart | input | 1 | Exception return executes |
| retBl | input | 1 | Block bit restored by the return |
| brkReq | output | 1 | User break request |
| brkPc | output | AW | PC to be saved for the break |
| brkTarget | output | AW | Handler entry address |
| flagA | output | 1 | Channel A match flag |
| flagB | output | 1 | Channel B match flag |
| savedSp | output | AW | Stack pointer copy |
| blockBit | output | 1 | Exception block bit |

## Verification
A stuck sequence-arming state shows at the ports as a missing channel B break, or as a break on a lone B, one cycle after the B access. A stale merge register shows as a doubled request, or as a dropped request with a repeated PC, in the cycle after the second access. Wrong flag state can be seen on `flagA`/`flagB` one cycle after the match or the clear. A wrong return pipeline shows as `blockBit` changing in the delay-slot cycle instead of one cycle later.

// File: rtl/dbgbrk_pkg.sv
package dbgbrk_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } accKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;  // capture break PC and target
    logic selB;   // take channel B candidate PC
    logic capSp;  // copy stack pointer
  } dpStrobe_t;
endpackage

// File: rtl/dbgbrk_dp.sv
module dbgbrk_dp
  import dbgbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int INSN_BYTES = 2,
  parameter int unsigned BRK_OFFSET = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [1:0]        accType,
  input  logic [AW-1:0]     accAddr,
  input  logic [AW-1:0]     accPc,
  input  logic [AW-1:0]     chAddr [NUM_CH],
  input  logic [AW-1:0]     chMask [NUM_CH],
  input  logic [1:0]        chType [NUM_CH],
  input  logic [NUM_CH-1:0] chPost,
  input  logic              debugEn,
  input  logic [AW-1:0]     dbgBase,
  input  logic [AW-1:0]     vecBase,
  input  logic [AW-1:0]     spIn,
  input  logic              flagWrEn,
  input  logic [NUM_CH-1:0] flagWrData,
  input  logic              brkReq,
  input  dpStrobe_t         stb,
  output logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] isPost,
  output logic [NUM_CH-1:0] sameLast,
  output logic [NUM_CH-1:0] flags,
  output logic [AW-1:0]     brkPc,
  output logic [AW-1:0]     brkTarget,
  output logic [AW-1:0]     savedSp
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);
  localparam logic [AW-1:0] OFS  = AW'(BRK_OFFSET);

  logic [AW-1:0] candPc [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    // timing select only counts for fetch matching
    assign isPost[g]   = (chType[g] != ACC_FETCH) | chPost[g];
    assign hit[g]      = accValid && (accType == chType[g]) &&
                         (((accAddr ^ chAddr[g]) & ~chMask[g]) == '0);
    assign candPc[g]   = isPost[g] ? accPc + STEP : accPc;
    assign sameLast[g] = (candPc[g] == brkPc);

    always_ff @(posedge clk) begin
      if (!rstN)                              flags[g] <= 1'b0;
      else if (hit[g])                        flags[g] <= 1'b1;
      else if (flagWrEn && !flagWrData[g])    flags[g] <= 1'b0;
    end

    a_r1_hit_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
      hit[g] |=> flags[g]);
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      flags[g] && !(flagWrEn && !flagWrData[g]) |=> flags[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brkPc     <= '0;
      brkTarget <= '0;
      savedSp   <= '0;
    end else begin
      if (stb.issue) begin
        brkPc     <= stb.selB ? candPc[1] : candPc[0];
        brkTarget <= debugEn ? dbgBase : vecBase + OFS;
      end
      if (stb.capSp) savedSp <= spIn;
    end
  end

  // R5: back-to-back requests never repeat a PC
  a_r5_no_repeat_pc: assert property (@(posedge clk) disable iff (!rstN)
    brkReq && stb.issue |=> brkPc != $past(brkPc));
endmodule

// File: rtl/dbgbrk_ctl.sv
module dbgbrk_ctl
  import dbgbrk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] isPost,
  input  logic [NUM_CH-1:0] sameLast,
  input  logic              seqMode,
  input  logic              excCompleted,
  input  logic              excReexec,
  input  logic              excAccept,
  input  logic              retStart,
  input  logic              retBl,
  output dpStrobe_t         stb,
  output logic              brkReq,
  output logic              blockBit
);
  logic              armed;
  logic              retPend;
  logic              retBlHold;
  logic [NUM_CH-1:0] cand;
  logic [NUM_CH-1:0] supp;
  logic [NUM_CH-1:0] live;

  always_comb begin
    cand[0]   = hit[0] & ~seqMode;
    cand[1]   = hit[1] & (~seqMode | armed);
    supp      = isPost & {NUM_CH{excCompleted | excReexec}};
    live      = cand & ~supp & ~(sameLast & {NUM_CH{brkReq}});
    stb.issue = |live;
    stb.selB  = live[1] & (~live[0] | (isPost[0] & ~isPost[1]));
    stb.capSp = brkReq | excAccept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      brkReq    <= 1'b0;
      retPend   <= 1'b0;
      retBlHold <= 1'b0;
      blockBit  <= 1'b1;
    end else begin
      brkReq  <= stb.issue;
      retPend <= retStart;
      if (retStart) retBlHold <= retBl;
      if (!seqMode)              armed <= 1'b0;
      else if (hit[1] && armed)  armed <= 1'b0;
      else if (hit[0])           armed <= 1'b1;
      if (brkReq || excAccept)   blockBit <= 1'b1;
      else if (retPend)          blockBit <= retBlHold;
    end
  end

  a_r6_seq_a_silent: assert property (@(posedge clk) disable iff (!rstN)
    seqMode && !hit[1] |=> !brkReq);
  a_r6_seq_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    seqMode && !armed |=> !brkReq);
  a_r7_post_loses: assert property (@(posedge clk) disable iff (!rstN)
    (excCompleted || excReexec) && !(|(hit & ~isPost)) |=> !brkReq);
  a_r10_accept_blocks: assert property (@(posedge clk) disable iff (!rstN)
    brkReq || excAccept |=> blockBit);
  a_r10_slot_keeps: assert property (@(posedge clk) disable iff (!rstN)
    retStart && !retPend && !brkReq && !excAccept |=> blockBit == $past(blockBit));
endmodule

// File: rtl/dbgBreakCtl.sv
module dbgBreakCtl
  import dbgbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int INSN_BYTES = 2,
  parameter int unsigned BRK_OFFSET = 'h100
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          accValid,
  input  logic [1:0]    accType,
  input  logic [AW-1:0] accAddr,
  input  logic [AW-1:0] accPc,
  input  logic [AW-1:0] aAddr,
  input  logic [AW-1:0] aMask,
  input  logic [1:0]    aType,
  input  logic          aPost,
  input  logic [AW-1:0] bAddr,
  input  logic [AW-1:0] bMask,
  input  logic [1:0]    bType,
  input  logic          bPost,
  input  logic          seqMode,
  input  logic          debugEn,
  input  logic [AW-1:0] dbgBase,
  input  logic [AW-1:0] vecBase,
  input  logic          flagWrEn,
  input  logic [1:0]    flagWrData,
  input  logic          excCompleted,
  input  logic          excReexec,
  input  logic          excAccept,
  input  logic [AW-1:0] spIn,
  input  logic          retStart,
  input  logic          retBl,
  output logic          brkReq,
  output logic [AW-1:0] brkPc,
  output logic [AW-1:0] brkTarget,
  output logic          flagA,
  output logic          flagB,
  output logic [AW-1:0] savedSp,
  output logic          blockBit
);
  logic [AW-1:0]     chAddr [NUM_CH];
  logic [AW-1:0]     chMask [NUM_CH];
  logic [1:0]        chType [NUM_CH];
  logic [NUM_CH-1:0] hit, isPost, sameLast, flags;
  dpStrobe_t         stb;

  assign chAddr[0] = aAddr;
  assign chAddr[1] = bAddr;
  assign chMask[0] = aMask;
  assign chMask[1] = bMask;
  assign chType[0] = aType;
  assign chType[1] = bType;
  assign flagA = flags[0];
  assign flagB = flags[1];

  dbgbrk_dp #(.AW(AW), .INSN_BYTES(INSN_BYTES), .BRK_OFFSET(BRK_OFFSET)) uDp (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accType(accType),
    .accAddr(accAddr), .accPc(accPc), .chAddr(chAddr), .chMask(chMask),
    .chType(chType), .chPost({bPost, aPost}), .debugEn(debugEn),
    .dbgBase(dbgBase), .vecBase(vecBase), .spIn(spIn), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .brkReq(brkReq), .stb(stb), .hit(hit),
    .isPost(isPost), .sameLast(sameLast), .flags(flags), .brkPc(brkPc),
    .brkTarget(brkTarget), .savedSp(savedSp)
  );

  dbgbrk_ctl uCtl (
    .clk(clk), .rstN(rstN), .hit(hit), .isPost(isPost), .sameLast(sameLast),
    .seqMode(seqMode), .excCompleted(excCompleted), .excReexec(excReexec),
    .excAccept(excAccept), .retStart(retStart), .retBl(retBl), .stb(stb),
    .brkReq(brkReq), .blockBit(blockBit)
  );
endmodule

// File: tb/sim_dbgBreakCtl.sv
module sim_dbgBreakCtl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 0; logic [1:0] accType = 0; logic [31:0] accAddr = 0, accPc = 0;
  logic [31:0] aAddr = 0, aMask = 0, bAddr = 0, bMask = 0;
  logic [1:0] aType = 0, bType = 0; logic aPost = 0, bPost = 0;
  logic seqMode = 0, debugEn = 0;
  logic [31:0] dbgBase = 32'hDEAD_0000, vecBase = 32'h8000_0000;
  logic flagWrEn = 0; logic [1:0] flagWrData = 0;
  logic excCompleted = 0, excReexec = 0, excAccept = 0;
  logic [31:0] spIn = 0; logic retStart = 0, retBl = 0;
  logic brkReq, flagA, flagB, blockBit;
  logic [31:0] brkPc, brkTarget, savedSp;

  int checks = 0, errors = 0, cyc = 0;
  bit running = 0, done = 0;
  logic [31:0] pcQ[$], tgtQ[$];
  int dueQ[$];
  string tagQ[$];

  localparam logic [1:0] FETCH = 2'd0, READ = 2'd1, WRITE = 2'd2;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbgBreakCtl u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expTgt();
    return debugEn ? dbgBase : vecBase + 32'h100;
  endfunction

  task automatic expectBrk(input logic [31:0] pc, input string tag);
    pcQ.push_back(pc); tgtQ.push_back(expTgt()); dueQ.push_back(cyc + 1); tagQ.push_back(tag);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic access(input logic [1:0] t, input logic [31:0] a, input logic [31:0] pc);
    accValid = 1; accType = t; accAddr = a; accPc = pc;
    step();
    accValid = 0;
  endtask

  task automatic flagWrite(input logic [1:0] d);
    flagWrEn = 1; flagWrData = d; step(); flagWrEn = 0;
  endtask

  task automatic chanA(input logic [31:0] ad, input logic [31:0] m, input logic [1:0] t, input logic p);
    aAddr = ad; aMask = m; aType = t; aPost = p;
  endtask

  task automatic chanB(input logic [31:0] ad, input logic [31:0] m, input logic [1:0] t, input logic p);
    bAddr = ad; bMask = m; bType = t; bPost = p;
  endtask

  // monitor: pops expected breaks
  always @(negedge clk) if (running) begin
    if (brkReq) begin
      checks++;
      if (pcQ.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected break act pc=%h exp none", brkPc);
      end else begin
        logic [31:0] ePc, eTgt; int eDue; string eTag;
        ePc = pcQ.pop_front(); eTgt = tgtQ.pop_front(); eDue = dueQ.pop_front(); eTag = tagQ.pop_front();
        if (brkPc !== ePc || brkTarget !== eTgt || cyc != eDue) begin
          errors++;
          $display("FAIL %s break act pc=%h tgt=%h cyc=%0d exp pc=%h tgt=%h cyc=%0d",
                   eTag, brkPc, brkTarget, cyc, ePc, eTgt, eDue);
        end
      end
    end else if (dueQ.size() > 0 && dueQ[0] <= cyc) begin
      checks++; errors++;
      $display("FAIL %s missing break act none exp pc=%h", tagQ[0], pcQ[0]);
      void'(pcQ.pop_front()); void'(tgtQ.pop_front()); void'(dueQ.pop_front()); void'(tagQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    chanA(32'h1000, 0, FETCH, 0);
    chanB(32'hFFFF_0000, 0, FETCH, 0);
    repeat (3) step();
    rstN = 1; step();
    // reset state
    chk("R4 reset brkReq", brkReq, 0);
    chk("R2 reset flags", {flagA, flagB}, 0);
    chk("R10 reset blockBit", blockBit, 1);
    chk("R9 reset savedSp", savedSp, 0);
    running = 1;

    // R1 R3 R8: pre-execution fetch break
    expectBrk(32'h1000, "R3 pre fetch");
    access(FETCH, 32'h1000, 32'h1000);
    chk("R1 flagA after match", flagA, 1);
    chk("R4 brkReq one cycle later", brkReq, 1);
    step();
    chk("R4 brkReq single pulse", brkReq, 0);
    flagWrite(2'b00);
    chk("R2 write-zero clears", {flagA, flagB}, 0);

    // R1 type and valid qualifiers
    access(READ, 32'h1000, 32'h1000);
    chk("R1 wrong kind no flag", flagA, 0);
    accAddr = 32'h1000; accType = FETCH; step();
    chk("R1 no valid no flag", flagA, 0);
    // R1 mask
    chanA(32'h1000, 32'hF, FETCH, 0);
    expectBrk(32'h100C, "R1 masked match");
    access(FETCH, 32'h100C, 32'h100C);
    step();
    access(FETCH, 32'h1010, 32'h1010);
    step();

    // R2 write-one keeps, clear B only
    chanB(32'h2000, 0, READ, 0);
    expectBrk(32'h0202, "R3 data read post");
    access(READ, 32'h2000, 32'h0200);
    step();
    chk("R2 both flags set", {flagA, flagB}, 2'b11);
    flagWrite(2'b01);
    chk("R2 write one keeps A, clears B", {flagA, flagB}, 2'b10);
    flagWrite(2'b00);
    // R2 clear and match together
    chanA(32'h1000, 0, FETCH, 0);
    flagWrEn = 1; flagWrData = 2'b00;
    expectBrk(32'h1000, "R2 clear plus match");
    access(FETCH, 32'h1000, 32'h1000);
    flagWrEn = 0;
    chk("R2 match wins over clear", {flagA, flagB}, 2'b10);
    step();

    // R3 post fetch; data write with timing select ignored
    chanA(32'h3000, 0, FETCH, 1);
    chanB(32'h4000, 0, WRITE, 0);
    expectBrk(32'h3002, "R3 post fetch");
    access(FETCH, 32'h3000, 32'h3000);
    step();
    expectBrk(32'h0102, "R3 write ignores timing select");
    access(WRITE, 32'h4000, 32'h0100);
    step();

    // R5 merge: A post at 110, B pre at 112, back to back
    chanA(32'h110, 0, FETCH, 1);
    chanB(32'h112, 0, FETCH, 0);
    flagWrite(2'b00);
    expectBrk(32'h112, "R5 merged first");
    access(FETCH, 32'h110, 32'h110);
    access(FETCH, 32'h112, 32'h112);
    step();
    chk("R5 both flags after merge", {flagA, flagB}, 2'b11);
    // separated by a gap: two requests
    expectBrk(32'h112, "R5 gap first");
    access(FETCH, 32'h110, 32'h110);
    step();
    expectBrk(32'h112, "R5 gap second");
    access(FETCH, 32'h112, 32'h112);
    step();
    // same cycle: pre preferred
    chanA(32'h400, 0, FETCH, 1);
    chanB(32'h400, 0, FETCH, 0);
    expectBrk(32'h400, "R5 same cycle pre preferred");
    access(FETCH, 32'h400, 32'h400);
    step();

    // R6 sequential: B, A, A, B, B
    chanA(32'h500, 0, FETCH, 0);
    chanB(32'h600, 0, FETCH, 0);
    seqMode = 1;
    flagWrite(2'b00);
    access(FETCH, 32'h600, 32'h600);
    chk("R6 lone B sets flag only", {flagA, flagB}, 2'b01);
    step();
    access(FETCH, 32'h500, 32'h500); step();
    access(FETCH, 32'h500, 32'h500); step();
    chk("R6 A sets flag only", flagA, 1);
    expectBrk(32'h600, "R6 B after A");
    access(FETCH, 32'h600, 32'h600); step(); step();
    access(FETCH, 32'h600, 32'h600); step();
    seqMode = 0;

    // R7 exception collision
    chanA(32'h700, 0, FETCH, 1);
    chanB(32'hFFFF_0000, 0, FETCH, 0);
    flagWrite(2'b00);
    excCompleted = 1;
    access(FETCH, 32'h700, 32'h700);
    excCompleted = 0;
    chk("R7 completed exc flag still set", flagA, 1);
    step();
    flagWrite(2'b00);
    excReexec = 1;
    access(FETCH, 32'h700, 32'h700);
    excReexec = 0;
    chk("R7 reexec exc flag still set", flagA, 1);
    step();
    aPost = 0;
    excCompleted = 1;
    expectBrk(32'h700, "R7 pre break unaffected");
    access(FETCH, 32'h700, 32'h700);
    excCompleted = 0;
    step();

    // R8 debug target
    debugEn = 1;
    expectBrk(32'h700, "R8 debug base target");
    access(FETCH, 32'h700, 32'h700);
    step();

    // R10 return delay slot, R9 sp copy
    retBl = 0; retStart = 1; step(); retStart = 0;
    chk("R10 delay slot keeps old", blockBit, 1);
    step();
    chk("R10 restored after slot", blockBit, 0);
    spIn = 32'h1234; excAccept = 1; step(); excAccept = 0;
    chk("R10 accept sets block", blockBit, 1);
    chk("R9 sp on exception", savedSp, 32'h1234);
    retStart = 1; step(); retStart = 0; step();
    chk("R10 cleared again", blockBit, 0);
    spIn = 32'h5555;
    expectBrk(32'h700, "R9 break with debug on");
    access(FETCH, 32'h700, 32'h700);
    step();
    chk("R10 break sets block", blockBit, 1);
    chk("R9 sp on break debugEn=1", savedSp, 32'h5555);
    step(); step();
    chk("R4 no pending expected breaks", pcQ.size(), 0);

    done = 1;
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule